// File: doc/BRIEF.md
# Bus Arbiter with Hold Timeout, Priority Classes and Parking

This block decides which of N bus masters owns a shared bus. Each master raises its bit of a request vector. The arbiter answers with a registered one-hot grant. A second input vector marks some masters as high priority. When ownership changes, those masters are considered before the normal ones. Inside each class the choice rotates, starting just past the most recent owner.

A master may keep the bus for as long as it requests it, with one limit. If it has held the grant for `HOLD_LIMIT` consecutive requesting cycles and another master is waiting, the grant is withdrawn. For that one cycle no master is granted, and a one-cycle timeout pulse is raised. The waiting masters are arbitrated in the following cycle, and the master that was cut off ranks last. If nobody else is waiting, the owner keeps the bus beyond the limit.

When no master is requesting, the grant stays parked on the last owner when `PARK` is 1. When nothing has ever been granted, or `PARK` is 0, the grant is empty in that case. A request that reaches an empty or parked bus is answered on the next clock edge.

Top module: `arb_tmo_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant vector is all zero and the timeout pulse is low.
- R2: At most one grant bit is high in any cycle.
- R3: When the grant is all zero and at least one request is high, a grant to a requesting master is visible one clock edge later.
- R4: When a new owner is chosen and any master that is both requesting and marked high priority exists, the new owner is one of those masters. A high-priority request does not take the bus from an owner that is still requesting.
- R5: Within a class, masters are ranked by ascending index, starting at the index just above the last owner and wrapping from N-1 to 0. After reset the last owner is taken as N-1, so index 0 ranks first.
- R6: When the owner drops its request while another master requests, the grant moves to the chosen master on the next edge, with no empty cycle.
- R7: If the owner requests for HOLD_LIMIT consecutive granted cycles (default 10) and another master requests in the last of those cycles, then on the next edge the grant becomes all zero and the timeout pulse is high for exactly that one cycle.
- R8: In the cycle after a timeout removal, a waiting master is granted. The master that was removed ranks last.
- R9: If no other master requests, the owner keeps the grant past HOLD_LIMIT and no timeout pulse is raised. A request that arrives after the limit has passed causes removal on the next edge.
- R10: With PARK=1, when no master requests, the grant stays on the last owner.
- R11: The hold count restarts whenever the grant moves, so every new owner gets a full HOLD_LIMIT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N | Request from each master |
| hi_pri_i | input | N | High-priority class marker for each master |
| gnt_o | output | N | Registered one-hot grant, or all zero |
| tmo_pulse_o | output | 1 | One-cycle pulse in the cycle a grant has been withdrawn by timeout |

## Verification
A hold counter that is off by one shows up at the ports as a grant withdrawn one cycle early or one cycle late, measured from the edge on which ownership began. A counter that fails to restart on a change of owner shortens the next owner's tenure. A stale rotation pointer shows up on the first arbitration after a handover, when a master with the wrong index is granted. A class decode fault shows up the first time normal and high-priority masters compete. All of these appear within one arbitration, or within HOLD_LIMIT+2 cycles of contention.

// File: rtl/arb_tmo_pkg.sv
package arb_tmo_pkg;
  // what the arbiter does with the bus on the coming edge
  typedef enum logic [2:0] {
    DEC_IDLE,    // nobody owns, nobody asks
    DEC_NEW,     // hand the bus to a freshly chosen master
    DEC_KEEP,    // owner still requesting, stays
    DEC_EXPIRE,  // owner over its limit with contention: withdraw
    DEC_PARK     // owner released, nobody else asks
  } dec_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  pick_o
);
  // lowest set bit as one-hot
  function automatic logic [N-1:0] low_one(input logic [N-1:0] v);
    return v & (~v + {{(N-1){1'b0}}, 1'b1});
  endfunction

  logic [N-1:0] above_mask;
  logic [N-1:0] masked;

  for (genvar gi = 0; gi < N; gi++) begin : g_mask
    assign above_mask[gi] = (gi > int'(last_i));
  end

  assign masked = vec_i & above_mask;
  assign pick_o = (|masked) ? low_one(masked) : low_one(vec_i);
endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  hi_pri_i,
  input  logic [IW-1:0] last_i,
  output logic [N-1:0]  pick_o
);
  logic [N-1:0] hi_req;
  logic [N-1:0] hi_pick;
  logic [N-1:0] all_pick;

  assign hi_req = req_i & hi_pri_i;

  rr_pick #(.N(N), .IW(IW)) u_hi (
    .vec_i (hi_req),
    .last_i(last_i),
    .pick_o(hi_pick)
  );

  rr_pick #(.N(N), .IW(IW)) u_all (
    .vec_i (req_i),
    .last_i(last_i),
    .pick_o(all_pick)
  );

  assign pick_o = (|hi_req) ? hi_pick : all_pick;
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_LIMIT = 10,
  parameter int unsigned CW         = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,     // new owner starts this edge
  input  logic stay_i,     // owner stays (keep or park)
  input  logic owner_req_i,
  output logic at_limit_o  // current cycle completes HOLD_LIMIT requesting cycles
);
  localparam logic [CW-1:0] TOP = CW'(HOLD_LIMIT - 1);

  // count of earlier requesting cycles of this tenure, saturating
  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c >= TOP) ? TOP : c + CW'(1);
  endfunction

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_i)      cnt_q <= '0;
    else if (stay_i)      cnt_q <= owner_req_i ? sat_inc(cnt_q) : '0;
    else                  cnt_q <= '0;
  end

  assign at_limit_o = (cnt_q >= TOP);
endmodule

// File: rtl/arb_tmo_top.sv
module arb_tmo_top #(
  parameter int unsigned N          = 4,
  parameter int unsigned HOLD_LIMIT = 10,
  parameter bit          PARK       = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] hi_pri_i,
  output logic [N-1:0] gnt_o,
  output logic         tmo_pulse_o
);
  import arb_tmo_pkg::*;

  localparam int unsigned IW = idx_w(N);
  localparam int unsigned CW = (HOLD_LIMIT > 1) ? $clog2(HOLD_LIMIT) : 1;

  function automatic logic [IW-1:0] onehot_idx(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = IW'(i);
    return r;
  endfunction

  logic [N-1:0]  gnt_q, gnt_d, pick;
  logic [IW-1:0] last_q, last_d;
  logic          tmo_q;
  logic          owned, owner_req, others_req, any_req, at_limit;
  dec_e          dec;

  // named events for the checker
  logic ev_new_grant, ev_expire, ev_keep, ev_park;

  assign owned      = |gnt_q;
  assign owner_req  = |(gnt_q & req_i);
  assign others_req = |(req_i & ~gnt_q);
  assign any_req    = |req_i;

  arb_select #(.N(N), .IW(IW)) u_sel (
    .req_i   (req_i),
    .hi_pri_i(hi_pri_i),
    .last_i  (last_q),
    .pick_o  (pick)
  );

  always_comb begin
    if (!owned)                                  dec = any_req ? DEC_NEW : DEC_IDLE;
    else if (owner_req && at_limit && others_req) dec = DEC_EXPIRE;
    else if (owner_req)                          dec = DEC_KEEP;
    else if (any_req)                            dec = DEC_NEW;
    else                                         dec = DEC_PARK;
  end

  assign ev_new_grant = (dec == DEC_NEW);
  assign ev_expire    = (dec == DEC_EXPIRE);
  assign ev_keep      = (dec == DEC_KEEP);
  assign ev_park      = (dec == DEC_PARK);

  logic [N-1:0] park_gnt;
  if (PARK) begin : g_park
    assign park_gnt = gnt_q;
  end else begin : g_nopark
    assign park_gnt = '0;
  end

  always_comb begin
    unique case (dec)
      DEC_NEW:  gnt_d = pick;
      DEC_KEEP: gnt_d = gnt_q;
      DEC_PARK: gnt_d = park_gnt;
      default:  gnt_d = '0;
    endcase
    last_d = ev_new_grant ? onehot_idx(pick) : last_q;
  end

  hold_timer #(.HOLD_LIMIT(HOLD_LIMIT), .CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (ev_new_grant),
    .stay_i     (ev_keep | ev_park),
    .owner_req_i(owner_req),
    .at_limit_o (at_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      last_q <= IW'(N - 1);
      tmo_q  <= 1'b0;
    end else begin
      gnt_q  <= gnt_d;
      last_q <= last_d;
      tmo_q  <= ev_expire;
    end
  end

  assign gnt_o       = gnt_q;
  assign tmo_pulse_o = tmo_q;
endmodule

// File: rtl/arb_tmo_chk.sv
module arb_tmo_chk #(
  parameter int unsigned N          = 4,
  parameter int unsigned HOLD_LIMIT = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req_i,
  input logic [N-1:0] hi_pri_i,
  input logic [N-1:0] gnt_o,
  input logic         tmo_pulse_o,
  input logic         ev_expire,
  input logic         ev_keep
);
  localparam int unsigned RW = $clog2(HOLD_LIMIT + 2);

  logic [N-1:0] gnt_prev;
  logic [RW-1:0] run;

  // contended requesting cycles of the same owner, counted independently
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_prev <= '0;
      run      <= '0;
    end else begin
      gnt_prev <= gnt_o;
      if (gnt_o != '0 && (gnt_o & req_i) != '0 && (req_i & ~gnt_o) != '0)
        run <= (gnt_o == gnt_prev && run != '0) ? run + RW'(1) : RW'(1);
      else
        run <= '0;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt_o));

  a_r1_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (gnt_o == '0 && !tmo_pulse_o));

  a_r3_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && req_i != '0) |=> ((gnt_o & $past(req_i)) != '0));

  a_r4_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0 && (req_i & hi_pri_i) != '0) |=> ((gnt_o & $past(hi_pri_i)) != '0));

  a_r7_expire_out: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> (tmo_pulse_o && gnt_o == '0));

  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse_o |=> !tmo_pulse_o);

  a_r7_hold_window: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(HOLD_LIMIT));

  a_r9_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ev_keep |=> (gnt_o == $past(gnt_o) && !tmo_pulse_o));
endmodule

bind arb_tmo_top arb_tmo_chk #(.N(N), .HOLD_LIMIT(HOLD_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .hi_pri_i   (hi_pri_i),
  .gnt_o      (gnt_o),
  .tmo_pulse_o(tmo_pulse_o),
  .ev_expire  (ev_expire),
  .ev_keep    (ev_keep)
);

// File: tb/arb_tmo_top_tb_top.sv
`timescale 1ns/1ps
module arb_tmo_top_tb_top;
  localparam int N     = 4;
  localparam int LIMIT = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] req, hi;
  logic [N-1:0] gnt;
  logic tmo;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  arb_tmo_top #(.N(N), .HOLD_LIMIT(LIMIT), .PARK(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .hi_pri_i(hi),
    .gnt_o(gnt), .tmo_pulse_o(tmo)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic [N-1:0] eg, input logic ep);
    n_run++;
    if (gnt !== eg || tmo !== ep) begin
      n_fail++;
      $display("FAIL %s: gnt=%b tmo=%b expected gnt=%b tmo=%b", rq, gnt, tmo, eg, ep);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; hi = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 4'b1111; hi = '0;
    tick();
    chk("R1 in reset", 4'b0000, 1'b0);
    req = '0; rst_n = 1'b1;
    tick();
    chk("R1 after reset", 4'b0000, 1'b0);
  endtask

  task automatic t_idle_park();
    do_reset();
    req = 4'b0010; tick();
    chk("R3 idle grant", 4'b0010, 1'b0);
    req = 4'b0000;
    for (int i = 0; i < 3; i++) begin
      tick(); chk("R10 park", 4'b0010, 1'b0);
    end
    req = 4'b1000; tick();
    chk("R3 parked bus answered", 4'b1000, 1'b0);
  endtask

  task automatic t_handover();
    do_reset();
    req = 4'b0010; tick();
    chk("R5 first pick", 4'b0010, 1'b0);
    req = 4'b0101; tick();
    chk("R6 no-gap handover / R5 after last", 4'b0100, 1'b0);
    req = 4'b0001; tick();
    chk("R5 wrap", 4'b0001, 1'b0);
  endtask

  task automatic t_priority();
    do_reset();
    req = 4'b0001; tick();
    chk("R4 setup", 4'b0001, 1'b0);
    hi = 4'b1000; req = 4'b1011; tick();
    chk("R4 no preempt", 4'b0001, 1'b0);
    req = 4'b1010; tick();
    chk("R4 hi wins", 4'b1000, 1'b0);
    do_reset();
    hi = 4'b0110; req = 4'b1111; tick();
    chk("R4 R5 hi class rr", 4'b0010, 1'b0);
    req = 4'b1101; tick();
    chk("R4 R5 next hi", 4'b0100, 1'b0);
    req = 4'b1001; tick();
    chk("R5 normal after last", 4'b1000, 1'b0);
  endtask

  task automatic t_timeout();
    int held;
    do_reset();
    req = 4'b0001; tick();
    chk("R7 start", 4'b0001, 1'b0);
    req = 4'b0011;
    for (int i = 2; i <= LIMIT; i++) begin
      tick(); chk("R7 held within limit", 4'b0001, 1'b0);
    end
    tick(); chk("R7 removal", 4'b0000, 1'b1);
    tick(); chk("R8 next grant", 4'b0010, 1'b0);
    held = 1;
    for (int i = 0; i < 2 * LIMIT && gnt == 4'b0010; i++) begin
      tick();
      if (gnt == 4'b0010) held++;
    end
    n_run++;
    if (held != LIMIT) begin
      n_fail++;
      $display("FAIL R11 tenure: held=%0d expected=%0d", held, LIMIT);
    end
    chk("R11 second removal", 4'b0000, 1'b1);
    tick(); chk("R8 removed ranks last", 4'b0001, 1'b0);
  endtask

  task automatic t_no_contend();
    do_reset();
    req = 4'b0100; tick();
    for (int i = 0; i < 2 * LIMIT + 5; i++) begin
      tick(); chk("R9 keep past limit", 4'b0100, 1'b0);
    end
    req = 4'b0101; tick();
    chk("R9 late contender removes", 4'b0000, 1'b1);
    tick(); chk("R8 R5 grant after late removal", 4'b0001, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; hi = '0;
    t_reset();
    t_idle_park();
    t_handover();
    t_priority();
    t_timeout();
    t_no_contend();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule